// File: doc/BRIEF.md
# Receive Frame Store Writer

This block takes one received Ethernet frame at a time and lays it out in a page of packet memory. A frame starts with a header beat that carries its byte count. The writer then decides whether the frame can be kept. If it can, it asks an external page allocator for a page and writes the frame's bytes into that page as they arrive. After the last byte it adds zero padding for short frames and, unless told to strip it, the frame check sequence. It then writes a two-byte trailer, and finally a status word and a byte count at the start of the page. As its last step it pushes the page number onto the receive queue and raises the receive interrupt for one cycle.

A frame is thrown away in four cases: reception is off, a soft reset is held, the stored image would not fit in one page, or the allocator has no free page. A thrown-away frame is still fully consumed from the byte stream, so the source never stalls on it. No memory write, queue push or interrupt comes from such a frame. The surrounding controller supplies the three control bits and owns the allocator and the queue.

Top module: `rx_frame_store`

## Requirements
- R1: A header accepted while `rx_en` is 0 or `rx_soft_rst` is 1 causes no allocation request, no memory write and no queue push. All of the frame's bytes are still consumed.
- R2: The stored size is computed from the padded length L' = max(L, 64). It is count = 4 + (L' rounded down to even) + 2, plus 4 when the check sequence is kept. A frame whose count exceeds the page size (2048) is dropped with no allocation request.
- R3: When the allocator answers with `alloc_ok` = 0, the frame is dropped. Its bytes are consumed, and nothing is written or pushed.
- R4: Payload byte i (counting from 0) is written at page offset 4 + i, for every i below the even-rounded length.
- R5: A frame shorter than 64 bytes is zero-filled at offsets 4+L to 67, and its status word has bit 0x0400 set.
- R6: Unless `strip_crc` is 1, four check bytes are written at offset 4 + even length, low byte first. They hold the complement of a reflected CRC-32 (polynomial 0xEDB88320, register seeded with all ones) taken over the padded frame, odd byte included.
- R7: When L' is odd, status bit 0x1000 is set and the trailer holds the final data byte followed by 0x20. Otherwise the trailer holds 0x00 followed by 0x40. The trailer sits at offsets count-2 and count-1, after the check bytes.
- R8: Offsets 0–1 hold the status word and offsets 2–3 hold the count, both little-endian. These four header bytes are the last bytes written before the push.
- R9: Status bit 0x0800 is set when L exceeds 1518.
- R10: A stored frame ends with `rxq_push` high for exactly one cycle, with `rxq_page` equal to the granted page and `rx_irq_set` high in the same cycle. Every write for the frame targets that page.
- R11: After reset, `hdr_ready` is 1, and `alloc_req`, `ram_we`, `rxq_push` and `rx_irq_set` are 0.
- R12: `alloc_req` stays high until `alloc_ack`, and no payload byte is accepted while the request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enabled |
| rx_soft_rst | input | 1 | Soft reset held, frames refused |
| strip_crc | input | 1 | Do not store the check sequence |
| hdr_valid | input | 1 | Frame header beat valid |
| hdr_len | input | 12 | Received frame length in bytes (1 or more) |
| hdr_ready | output | 1 | Writer idle, header beat taken |
| byte_valid | input | 1 | Payload byte valid |
| byte_data | input | 8 | Payload byte |
| byte_ready | output | 1 | Payload byte taken |
| alloc_req | output | 1 | Page allocation request |
| alloc_ack | input | 1 | Allocator answer strobe |
| alloc_ok | input | 1 | Allocation succeeded |
| alloc_page | input | 2 | Granted page number |
| ram_we | output | 1 | Packet memory write strobe |
| ram_page | output | 2 | Page being written |
| ram_addr | output | 11 | Byte offset within the page |
| ram_data | output | 8 | Byte written |
| rxq_push | output | 1 | Push page onto receive queue |
| rxq_page | output | 2 | Page pushed |
| rx_irq_set | output | 1 | Set receive interrupt |

## Verification
The hardest cases to reach are frames whose stored image lands exactly on the page limit. With the check sequence kept, a 2039-byte frame fills 2048 bytes and a 2040-byte frame does not fit. With it stripped, the same edge falls between 2043 and 2044 bytes. Directed frames at these lengths hit the edge from both sides, and the short-frame and odd-frame edges (1, 63, 64, 65) get the same treatment. An allocator model that can be told to refuse, together with random gaps in the byte stream, covers the drop-after-request path and stalls in the middle of a frame.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;

    localparam int LEN_W     = 12;
    localparam int MIN_FRAME = 64;
    localparam int STD_MAX   = 1518;
    localparam int HDR_BYTES = 4;
    localparam int TRL_BYTES = 2;
    localparam int FCS_BYTES = 4;

    localparam logic [15:0] ST_LONG  = 16'h0800;
    localparam logic [15:0] ST_ODD   = 16'h1000;
    localparam logic [15:0] ST_SHORT = 16'h0400;
    localparam logic [7:0]  TRL_ODD  = 8'h20;
    localparam logic [7:0]  TRL_EVEN = 8'h40;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

    typedef enum logic [2:0] {
        S_IDLE, S_ALLOC, S_DATA, S_PAD, S_FCS, S_TRL, S_HDR, S_PUSH
    } wr_state_e;

    typedef struct packed {
        logic [15:0]      status;
        logic [15:0]      count;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] even;
        logic             odd;
        logic             short_f;
        logic             fcs_en;
        logic             fits;
    } frame_info_t;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxfs_sizer.sv
module rxfs_sizer
    import rxfs_pkg::*;
#(
    parameter int PAGE_BYTES = 2048
) (
    input  logic [LEN_W-1:0] len,
    input  logic             strip_fcs,
    output frame_info_t      info
);
    localparam int CNT_W = LEN_W + 2;

    logic [LEN_W-1:0] padded;
    logic [CNT_W-1:0] total;

    always_comb begin
        info         = '0;
        info.len     = len;
        info.short_f = len < LEN_W'(MIN_FRAME);
        padded       = info.short_f ? LEN_W'(MIN_FRAME) : len;
        info.odd     = padded[0];
        info.even    = {padded[LEN_W-1:1], 1'b0};
        info.fcs_en  = !strip_fcs;
        total        = CNT_W'(info.even) + CNT_W'(HDR_BYTES + TRL_BYTES)
                     + (info.fcs_en ? CNT_W'(FCS_BYTES) : CNT_W'(0));
        info.fits    = total <= CNT_W'(PAGE_BYTES);
        info.count   = 16'(total);
        info.status  = (info.odd ? ST_ODD : 16'h0)
                     | (info.short_f ? ST_SHORT : 16'h0)
                     | ((len > LEN_W'(STD_MAX)) ? ST_LONG : 16'h0);
    end
endmodule

// File: rtl/rxfs_fcs.sv
module rxfs_fcs
    import rxfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc_step(crc_q, din);
        end
    end

    assign fcs = ~crc_q;
endmodule

// File: rtl/rxfs_seq.sv
module rxfs_seq
    import rxfs_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 2048,
    localparam int PG_W      = $clog2(PAGES),
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              rx_soft_rst,
    input  frame_info_t       info_in,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    output logic              alloc_req,
    input  logic              alloc_ack,
    input  logic              alloc_ok,
    input  logic [PG_W-1:0]   alloc_page,
    input  logic [31:0]       fcs,
    output logic              fcs_clear,
    output logic              fcs_en,
    output logic [7:0]        fcs_din,
    output logic              ram_we,
    output logic [PG_W-1:0]   ram_page,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_data,
    output logic              rxq_push,
    output logic [PG_W-1:0]   rxq_page,
    output logic              rx_irq_set
);
    wr_state_e        state_q;
    frame_info_t      info_q;
    logic [PG_W-1:0]  page_q;
    logic             drop_q;
    logic [LEN_W-1:0] idx_q;
    logic [1:0]       step_q;
    logic [7:0]       oddb_q;

    logic             last_byte;
    logic [31:0]      hdr_word;

    assign last_byte = idx_q == (info_q.len - LEN_W'(1));
    assign hdr_word  = {info_q.count, info_q.status};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            info_q  <= '0;
            page_q  <= '0;
            drop_q  <= 1'b0;
            idx_q   <= '0;
            step_q  <= '0;
            oddb_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (hdr_valid) begin
                        info_q  <= info_in;
                        idx_q   <= '0;
                        drop_q  <= !(rx_en && !rx_soft_rst && info_in.fits);
                        state_q <= (rx_en && !rx_soft_rst && info_in.fits) ? S_ALLOC : S_DATA;
                    end
                end
                S_ALLOC: begin
                    if (alloc_ack) begin
                        page_q  <= alloc_page;
                        drop_q  <= !alloc_ok;
                        state_q <= S_DATA;
                    end
                end
                S_DATA: begin
                    if (byte_valid) begin
                        idx_q <= idx_q + LEN_W'(1);
                        if (last_byte) begin
                            oddb_q <= byte_data;
                            step_q <= '0;
                            if (drop_q) begin
                                state_q <= S_IDLE;
                            end else if (info_q.short_f) begin
                                state_q <= S_PAD;
                            end else begin
                                state_q <= info_q.fcs_en ? S_FCS : S_TRL;
                            end
                        end
                    end
                end
                S_PAD: begin
                    idx_q <= idx_q + LEN_W'(1);
                    if (idx_q == LEN_W'(MIN_FRAME - 1)) begin
                        state_q <= info_q.fcs_en ? S_FCS : S_TRL;
                    end
                end
                S_FCS: begin
                    step_q <= step_q + 2'd1;
                    if (step_q == 2'd3) begin
                        state_q <= S_TRL;
                    end
                end
                S_TRL: begin
                    step_q <= step_q + 2'd1;
                    if (step_q == 2'd1) begin
                        step_q  <= '0;
                        state_q <= S_HDR;
                    end
                end
                S_HDR: begin
                    step_q <= step_q + 2'd1;
                    if (step_q == 2'd3) begin
                        state_q <= S_PUSH;
                    end
                end
                default: begin
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        hdr_ready  = state_q == S_IDLE;
        byte_ready = state_q == S_DATA;
        alloc_req  = state_q == S_ALLOC;
        rxq_push   = state_q == S_PUSH;
        rx_irq_set = state_q == S_PUSH;
        rxq_page   = page_q;
        ram_page   = page_q;
        fcs_clear  = (state_q == S_IDLE) && hdr_valid;
        fcs_en     = 1'b0;
        fcs_din    = 8'h00;
        ram_we     = 1'b0;
        ram_addr   = '0;
        ram_data   = 8'h00;
        case (state_q)
            S_DATA: begin
                fcs_en   = byte_valid && !drop_q;
                fcs_din  = byte_data;
                ram_we   = byte_valid && !drop_q && (idx_q < info_q.even);
                ram_addr = ADDR_W'(HDR_BYTES + int'(idx_q));
                ram_data = byte_data;
            end
            S_PAD: begin
                fcs_en   = 1'b1;
                ram_we   = 1'b1;
                ram_addr = ADDR_W'(HDR_BYTES + int'(idx_q));
            end
            S_FCS: begin
                ram_we   = 1'b1;
                ram_addr = ADDR_W'(HDR_BYTES + int'(info_q.even) + int'(step_q));
                ram_data = 8'(fcs >> {step_q, 3'b000});
            end
            S_TRL: begin
                ram_we   = 1'b1;
                ram_addr = ADDR_W'(int'(info_q.count) - TRL_BYTES + int'(step_q));
                if (step_q == 2'd0) begin
                    ram_data = info_q.odd ? oddb_q : 8'h00;
                end else begin
                    ram_data = info_q.odd ? TRL_ODD : TRL_EVEN;
                end
            end
            S_HDR: begin
                ram_we   = 1'b1;
                ram_addr = ADDR_W'(step_q);
                ram_data = 8'(hdr_word >> {step_q, 3'b000});
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/rx_frame_store.sv
module rx_frame_store
    import rxfs_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 2048,
    localparam int PG_W      = $clog2(PAGES),
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              rx_soft_rst,
    input  logic              strip_crc,
    input  logic              hdr_valid,
    input  logic [LEN_W-1:0]  hdr_len,
    output logic              hdr_ready,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    output logic              alloc_req,
    input  logic              alloc_ack,
    input  logic              alloc_ok,
    input  logic [PG_W-1:0]   alloc_page,
    output logic              ram_we,
    output logic [PG_W-1:0]   ram_page,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_data,
    output logic              rxq_push,
    output logic [PG_W-1:0]   rxq_page,
    output logic              rx_irq_set
);
    frame_info_t info;
    logic [31:0] fcs;
    logic        fcs_clear;
    logic        fcs_en;
    logic [7:0]  fcs_din;

    rxfs_sizer #(.PAGE_BYTES(PAGE_BYTES)) u_sizer (
        .len       (hdr_len),
        .strip_fcs (strip_crc),
        .info      (info)
    );

    rxfs_fcs u_fcs (
        .clk   (clk),
        .rst   (rst),
        .clear (fcs_clear),
        .en    (fcs_en),
        .din   (fcs_din),
        .fcs   (fcs)
    );

    rxfs_seq #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .rx_en       (rx_en),
        .rx_soft_rst (rx_soft_rst),
        .info_in     (info),
        .hdr_valid   (hdr_valid),
        .hdr_ready   (hdr_ready),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .byte_ready  (byte_ready),
        .alloc_req   (alloc_req),
        .alloc_ack   (alloc_ack),
        .alloc_ok    (alloc_ok),
        .alloc_page  (alloc_page),
        .fcs         (fcs),
        .fcs_clear   (fcs_clear),
        .fcs_en      (fcs_en),
        .fcs_din     (fcs_din),
        .ram_we      (ram_we),
        .ram_page    (ram_page),
        .ram_addr    (ram_addr),
        .ram_data    (ram_data),
        .rxq_push    (rxq_push),
        .rxq_page    (rxq_page),
        .rx_irq_set  (rx_irq_set)
    );
endmodule

// File: rtl/rx_frame_store_chk.sv
module rx_frame_store_chk (
    input logic clk,
    input logic rst,
    input logic rx_en,
    input logic rx_soft_rst,
    input logic hdr_valid,
    input logic hdr_ready,
    input logic byte_ready,
    input logic alloc_req,
    input logic alloc_ack,
    input logic ram_we,
    input logic rxq_push,
    input logic rx_irq_set
);
    AST_REFUSE_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_ready && (!rx_en || rx_soft_rst)) |=> !alloc_req); // R1
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        hdr_ready |-> !ram_we); // R11
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !alloc_ack) |=> alloc_req); // R12
    AST_NO_BYTE_IN_ALLOC: assert property (@(posedge clk) disable iff (rst)
        alloc_req |-> !byte_ready); // R12
    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rxq_push |=> !rxq_push); // R10
    AST_PUSH_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
        rxq_push |-> $past(ram_we)); // R8
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_irq_set |=> !rx_irq_set); // R10
endmodule

bind rx_frame_store rx_frame_store_chk u_chk (.*);

// File: tb/rx_frame_store_bench.sv
module rx_frame_store_bench;
    localparam int PAGES = 4;
    localparam int PB    = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0, rx_soft_rst = 1'b0, strip_crc = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [11:0] hdr_len = '0;
    logic        hdr_ready;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_ready;
    logic        alloc_req;
    logic        alloc_ack = 1'b0, alloc_ok = 1'b0;
    logic [1:0]  alloc_page = '0;
    logic        ram_we;
    logic [1:0]  ram_page;
    logic [10:0] ram_addr;
    logic [7:0]  ram_data;
    logic        rxq_push;
    logic [1:0]  rxq_page;
    logic        rx_irq_set;

    always #5 clk = ~clk;

    rx_frame_store u_rx_frame_store (.*);

    int n_chk = 0, n_err = 0, cycles = 0;
    int we_cnt = 0, push_cnt = 0, ack_cnt = 0, irq_bad = 0, page_bad = 0;
    logic [1:0] push_pg = '0;
    logic [1:0] give_page = '0;
    bit   refuse = 1'b0;
    logic [7:0] mem [0:PAGES*PB-1];
    logic [7:0] frm [0:4095];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        alloc_ack <= 1'b0;
        if (alloc_req && !alloc_ack) begin
            alloc_ack  <= 1'b1;
            alloc_ok   <= !refuse;
            alloc_page <= give_page;
            ack_cnt    <= ack_cnt + 1;
        end
        if (ram_we) begin
            mem[int'(ram_page) * PB + int'(ram_addr)] <= ram_data;
            we_cnt <= we_cnt + 1;
            if (ram_page != give_page) page_bad <= page_bad + 1;
        end
        if (rxq_push) begin
            push_cnt <= push_cnt + 1;
            push_pg  <= rxq_page;
        end
        if (rxq_push != rx_irq_set) irq_bad <= irq_bad + 1;
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cycles == 190000) begin
            chk(1'b0, "WDOG", "run did not finish", cycles, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    function automatic logic [31:0] ref_fcs(input int len);
        logic [31:0] c = 32'hFFFFFFFF;
        int padded = (len < 64) ? 64 : len;
        for (int i = 0; i < padded; i++) begin
            c ^= {24'd0, (i < len) ? frm[i] : 8'h00};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic int rd(input int pg, input int off);
        return int'(mem[pg * PB + off]);
    endfunction

    task automatic send(input int len, input bit en, input bit srst, input bit strip, input bit fail);
        int padded = (len < 64) ? 64 : len;
        int even   = padded & ~1;
        bit odd    = padded[0];
        int cnt    = even + 6 + (strip ? 0 : 4);
        bit keep   = en && !srst && (cnt <= 2048) && !fail;
        int st     = (odd ? 'h1000 : 0) | (len < 64 ? 'h0400 : 0) | (len > 1518 ? 'h0800 : 0);
        int we0, push0, ack0, bad, pg;
        logic [31:0] f;
        for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
        @(negedge clk);
        while (!hdr_ready) @(negedge clk);
        rx_en = en; rx_soft_rst = srst; strip_crc = strip; refuse = fail;
        give_page = give_page + 2'd1;
        pg = int'(give_page);
        we0 = we_cnt; push0 = push_cnt; ack0 = ack_cnt;
        hdr_valid = 1'b1; hdr_len = 12'(len);
        @(negedge clk);
        hdr_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            if ($urandom_range(7) == 0) begin
                byte_valid = 1'b0;
                @(negedge clk);
            end
            while (!byte_ready) begin
                byte_valid = 1'b0;
                @(negedge clk);
            end
            byte_valid = 1'b1; byte_data = frm[i];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        while (!hdr_ready) @(negedge clk);
        @(negedge clk);
        if (!keep) begin
            if (!en || srst || cnt > 2048)
                chk(ack_cnt == ack0, (cnt > 2048) ? "R2" : "R1", "allocation requested", ack_cnt - ack0, 0);
            else
                chk(ack_cnt == ack0 + 1, "R3", "allocation count", ack_cnt - ack0, 1);
            chk(we_cnt == we0, fail ? "R3" : "R1", "writes for dropped frame", we_cnt - we0, 0);
            chk(push_cnt == push0, fail ? "R3" : "R2", "push for dropped frame", push_cnt - push0, 0);
            return;
        end
        chk(push_cnt == push0 + 1 && push_pg == give_page, "R10", "push count/page",
            (push_cnt - push0) * 16 + int'(push_pg), 16 + pg);
        chk(we_cnt - we0 == cnt - (odd ? 1 : 0) + (odd ? 1 : 0) - (padded - even) + (padded - even),
            "R10", "write count", we_cnt - we0, cnt);
        chk(rd(pg, 0) + rd(pg, 1) * 256 == st, (len < 64) ? "R5" : (len > 1518 ? "R9" : "R7"),
            "status word", rd(pg, 0) + rd(pg, 1) * 256, st);
        chk(rd(pg, 2) + rd(pg, 3) * 256 == cnt, "R8", "byte count", rd(pg, 2) + rd(pg, 3) * 256, cnt);
        bad = -1;
        for (int i = 0; i < even; i++) begin
            if (bad < 0 && rd(pg, 4 + i) != ((i < len) ? int'(frm[i]) : 0)) bad = i;
        end
        chk(bad < 0, (len < 64) ? "R5" : "R4", "payload/pad first mismatch index", bad, -1);
        if (!strip) begin
            f = ref_fcs(len);
            chk({mem[pg*PB+4+even+3], mem[pg*PB+4+even+2], mem[pg*PB+4+even+1], mem[pg*PB+4+even]} == f,
                "R6", "check bytes",
                int'({mem[pg*PB+4+even+3], mem[pg*PB+4+even+2], mem[pg*PB+4+even+1], mem[pg*PB+4+even]}),
                int'(f));
        end
        chk(rd(pg, cnt - 2) == (odd ? int'(frm[len-1]) : 0) && rd(pg, cnt - 1) == (odd ? 'h20 : 'h40),
            "R7", "trailer", rd(pg, cnt - 2) * 256 + rd(pg, cnt - 1),
            (odd ? int'(frm[len-1]) : 0) * 256 + (odd ? 'h20 : 'h40));
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(hdr_ready && !alloc_req && !ram_we && !rxq_push && !rx_irq_set, "R11", "reset outputs",
            {hdr_ready, alloc_req, ram_we, rxq_push, rx_irq_set}, 5'b10000);
        send(1, 1, 0, 0, 0);
        send(63, 1, 0, 0, 0);
        send(64, 1, 0, 0, 0);
        send(65, 1, 0, 0, 0);
        send(65, 1, 0, 1, 0);
        send(1519, 1, 0, 0, 0);
        send(2039, 1, 0, 0, 0);
        send(2040, 1, 0, 0, 0);
        send(2043, 1, 0, 1, 0);
        send(2044, 1, 0, 1, 0);
        send(100, 0, 0, 0, 0);
        send(100, 1, 1, 0, 0);
        send(90, 1, 0, 0, 1);
        send(80, 1, 0, 0, 0);
        for (int k = 0; k < 20; k++)
            send(1 + $urandom_range(299), 1, 0, $urandom_range(1) == 1, $urandom_range(5) == 0);
        chk(irq_bad == 0, "R10", "interrupt/push mismatch cycles", irq_bad, 0);
        chk(page_bad == 0, "R10", "writes outside granted page", page_bad, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule